// File: doc/BRIEF.md
# Wavetable PWM Tone Voice

This block produces a single audio voice on one digital pin. Software programs a waveform choice, a phase step, a gain and a note length through a small write-only register port, then issues a start command. While the note plays, a 16-bit phase accumulator advances by the step once per sample. Its upper bits index a waveform. The resulting level is scaled by the gain and becomes the duty cycle of an 8-bit pulse-width modulator. A larger step sweeps the waveform faster and so raises the pitch.

One sample is taken per PWM period of 256 clocks, so the sample rate is the clock rate divided by 256. The note length counts samples. Only a steady sustained tone is produced: there is no attack, decay or release shaping. When the count runs out, the voice falls back to the midpoint level, which is silence after the usual external low-pass filter, and the busy flag drops.

Register map (address on `wr_addr`): 0 selects the waveform (data bits 2:0), 1 sets the phase step (16 bits), 2 sets the gain (bits 7:0), 3 sets the note length in samples (16 bits), and 4 starts a note (data ignored).

Top module: `tone_voice`

## Requirements
- R1: After reset and whenever no note is playing, `busy` is 0 and the PWM duty is 128, so the pin is high for exactly the first 128 clocks of every period.
- R2: The PWM period is 256 clocks, counted from the first rising edge after reset release; within a period the pin is high for exactly `duty` clocks at its start, and a new duty takes effect only at a period boundary.
- R3: A write to address 4 with a nonzero stored length L sets `busy` on the next edge. The following L period boundaries load note samples 0..L-1. `busy` clears at the boundary that loads sample L-1, and the next boundary loads 128.
- R4: A start clears the phase to 0; note sample k uses table index = bits 15:8 of (k × step mod 65536).
- R5: Waveform code 3 (sawtooth) gives level = index.
- R6: Waveform code 2 (square) gives level 255 for index < 128 and 0 otherwise; codes 5, 6 and 7 give level 128.
- R7: Waveform code 1 (triangle) gives 2·index for index < 128 and 2·(255 − index) otherwise.
- R8: Waveform code 0 (sine) with h = index mod 128 and o = floor(h·(127 − h)·127 / 4096) gives 128 + o for index < 128 and 128 − o otherwise.
- R9: Waveform code 4 (noise) gives the low 8 bits of a 16-bit shift register. The register is loaded with 0xACE1 at start and shifts left once per note sample, taking in the XOR of its bits 15, 14, 12 and 3. Sample k uses the value after k shifts.
- R10: With gain A and level v, the duty during a note is 128 + floor((v − 128)·A / 256).
- R11: A start write while the stored length is 0 has no effect: `busy` stays 0 and the duty stays 128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 wave, 1 step, 2 gain, 3 length, 4 start) |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 1 | Pulse-width modulated audio pin |
| busy | output | 1 | High while a note is playing |

## Verification
A corrupted phase, noise register or waveform select shows up in the measured duty of the very next PWM period. That is at most 256 clocks after the fault, because every note sample is compared as a per-period high-time count. A wrong note counter shows as a period that should be silent but is not, or a missing sample. A wrong counter also shows as `busy` changing one boundary early or late, which the bench samples on both sides of the last sample boundary. A duty register updated mid-period shows up as a high-time count that matches neither the old sample nor the new one.

// File: rtl/tone_pkg.sv
package tone_pkg;

   typedef enum logic [2:0] {
      WAVE_SINE   = 3'd0,
      WAVE_TRI    = 3'd1,
      WAVE_SQUARE = 3'd2,
      WAVE_SAW    = 3'd3,
      WAVE_NOISE  = 3'd4
   } wave_e;

   localparam int REG_WAVE  = 0;
   localparam int REG_STEP  = 1;
   localparam int REG_GAIN  = 2;
   localparam int REG_LEN   = 3;
   localparam int REG_START = 4;

endpackage

// File: rtl/tone_phase.sv
module tone_phase #(
   parameter int PHASE_W = 16,
   parameter int IDX_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               advance,
   input  logic [PHASE_W-1:0] step,
   output logic [IDX_W-1:0]   idx
);

   if (IDX_W > PHASE_W) begin : g_chk_width
      $error("tone_phase: index wider than accumulator");
   end

   logic [PHASE_W-1:0] acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clear) begin
         acc_q <= '0;
      end else if (advance) begin
         acc_q <= acc_q + step;
      end
   end

   assign idx = acc_q[PHASE_W-1 -: IDX_W];

endmodule

// File: rtl/tone_wave.sv
module tone_wave
   import tone_pkg::*;
#(
   parameter int          IDX_W    = 8,
   parameter int          SAMPLE_W = 8,
   parameter int          LFSR_W   = 16,
   parameter logic [15:0] SEED     = 16'hACE1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          sel,
   input  logic [IDX_W-1:0]    idx,
   input  logic                reseed,
   input  logic                noise_adv,
   output logic [SAMPLE_W-1:0] level
);

   localparam int TBL_DEPTH = 1 << IDX_W;
   localparam int MID_I     = 1 << (SAMPLE_W - 1);
   localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(MID_I);
   localparam logic [LFSR_W-1:0]   SEED_W = LFSR_W'(SEED);

   if (IDX_W != SAMPLE_W) begin : g_chk_idx
      $error("tone_wave: index and sample widths must match");
   end
   if (LFSR_W != 8 && LFSR_W != 16) begin : g_chk_lfsr
      $error("tone_wave: noise register must be 8 or 16 bits");
   end
   if (LFSR_W < SAMPLE_W) begin : g_chk_noise
      $error("tone_wave: noise register narrower than sample");
   end
   if (SEED_W == '0) begin : g_chk_seed
      $error("tone_wave: noise seed must be nonzero");
   end

   // Parabolic half-wave approximation of a sine, evaluated per entry.
   function automatic logic [SAMPLE_W-1:0] sine_at(input int i);
      int half;
      int quarter;
      int h;
      int off;
      half    = TBL_DEPTH / 2;
      quarter = half / 2;
      h       = i % half;
      off     = (h * (half - 1 - h) * (MID_I - 1)) / (quarter * quarter);
      if (i < half) return SAMPLE_W'(MID_I + off);
      else          return SAMPLE_W'(MID_I - off);
   endfunction

   logic [SAMPLE_W-1:0] sine_rom [TBL_DEPTH];

   for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_rom
      assign sine_rom[g] = sine_at(g);
   end

   // Noise source
   logic [LFSR_W-1:0] lfsr_q;
   logic              fb;

   if (LFSR_W == 16) begin : g_fb16
      assign fb = lfsr_q[15] ^ lfsr_q[14] ^ lfsr_q[12] ^ lfsr_q[3];
   end else begin : g_fb8
      assign fb = lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lfsr_q <= SEED_W;
      end else if (reseed) begin
         lfsr_q <= SEED_W;
      end else if (noise_adv) begin
         lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
      end
   end

   // Waveform shapes
   logic [SAMPLE_W-1:0] tri_lvl;
   logic [SAMPLE_W-1:0] sq_lvl;
   wave_e               sel_e;

   assign tri_lvl = idx[IDX_W-1] ? {~idx[IDX_W-2:0], 1'b0} : {idx[IDX_W-2:0], 1'b0};
   assign sq_lvl  = idx[IDX_W-1] ? '0 : '1;
   assign sel_e   = wave_e'(sel);

   always_comb begin
      case (sel_e)
         WAVE_SINE:   level = sine_rom[idx];
         WAVE_TRI:    level = tri_lvl;
         WAVE_SQUARE: level = sq_lvl;
         WAVE_SAW:    level = idx;
         WAVE_NOISE:  level = lfsr_q[SAMPLE_W-1:0];
         default:     level = MID;
      endcase
   end

   // R9: a maximal-length register must never reach the all-zero lock-up state
   a_r9_noise_alive: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0);

endmodule

// File: rtl/tone_scale.sv
module tone_scale #(
   parameter int SAMPLE_W = 8,
   parameter int AMP_W    = 8,
   parameter bit CENTERED = 1'b1
) (
   input  logic [SAMPLE_W-1:0] level,
   input  logic [AMP_W-1:0]    gain,
   input  logic                active,
   output logic [SAMPLE_W-1:0] duty
);

   localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1 << (SAMPLE_W - 1));

   if (AMP_W < 1 || SAMPLE_W < 2) begin : g_chk_width
      $error("tone_scale: widths too small");
   end

   logic [SAMPLE_W-1:0] scaled;

   if (CENTERED) begin : g_centered
      localparam int PW = SAMPLE_W + AMP_W + 2;
      logic signed [SAMPLE_W:0] centred;
      logic signed [AMP_W:0]    g_s;
      logic signed [PW-1:0]     prod;
      logic [SAMPLE_W-1:0]      offs;
      assign centred = $signed({1'b0, level}) - $signed({1'b0, MID});
      assign g_s     = $signed({1'b0, gain});
      assign prod    = PW'(centred) * PW'(g_s);
      assign offs    = SAMPLE_W'(prod >>> AMP_W);
      assign scaled  = MID + offs;
   end else begin : g_plain
      logic [SAMPLE_W+AMP_W-1:0] prod;
      assign prod   = level * gain;
      assign scaled = SAMPLE_W'(prod >> AMP_W);
   end

   assign duty = active ? scaled : MID;

endmodule

// File: rtl/tone_pwm.sv
module tone_pwm #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] duty_in,
   output logic             wrap,
   output logic [WIDTH-1:0] duty,
   output logic             pwm_out
);

   localparam logic [WIDTH-1:0] MID = WIDTH'(1 << (WIDTH - 1));

   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] duty_q;

   assign wrap = &cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         duty_q <= MID;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         if (wrap) begin
            duty_q <= duty_in;
         end
      end
   end

   assign pwm_out = cnt_q < duty_q;
   assign duty    = duty_q;

endmodule

// File: rtl/tone_voice.sv
module tone_voice
   import tone_pkg::*;
#(
   parameter int          ADDR_W   = 3,
   parameter int          DATA_W   = 16,
   parameter int          PHASE_W  = 16,
   parameter int          SAMPLE_W = 8,
   parameter int          AMP_W    = 8,
   parameter int          DUR_W    = 16,
   parameter int          LFSR_W   = 16,
   parameter logic [15:0] SEED     = 16'hACE1,
   parameter bit          CENTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              pwm_out,
   output logic              busy
);

   localparam int IDX_W = SAMPLE_W;
   localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1 << (SAMPLE_W - 1));

   if (DATA_W < PHASE_W || DATA_W < DUR_W || DATA_W < AMP_W) begin : g_chk_data
      $error("tone_voice: write data narrower than a register");
   end
   if ((1 << ADDR_W) <= REG_START) begin : g_chk_addr
      $error("tone_voice: address too narrow for register map");
   end

   // Settings
   logic [2:0]          wave_q;
   logic [PHASE_W-1:0]  step_q;
   logic [AMP_W-1:0]    gain_q;
   logic [DUR_W-1:0]    len_q;
   logic                start_wr;
   logic                start_go;

   assign start_wr = wr_en && (wr_addr == ADDR_W'(REG_START));
   assign start_go = start_wr && (len_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wave_q <= '0;
         step_q <= '0;
         gain_q <= '0;
         len_q  <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(REG_WAVE)) wave_q <= wr_data[2:0];
         if (wr_addr == ADDR_W'(REG_STEP)) step_q <= wr_data[PHASE_W-1:0];
         if (wr_addr == ADDR_W'(REG_GAIN)) gain_q <= wr_data[AMP_W-1:0];
         if (wr_addr == ADDR_W'(REG_LEN))  len_q  <= wr_data[DUR_W-1:0];
      end
   end

   // Note timer
   logic             busy_q;
   logic [DUR_W-1:0] left_q;
   logic             tick;
   logic             sample_adv;

   assign sample_adv = tick && busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         left_q <= '0;
      end else if (start_go) begin
         busy_q <= 1'b1;
         left_q <= len_q;
      end else if (sample_adv) begin
         left_q <= left_q - 1'b1;
         if (left_q == DUR_W'(1)) begin
            busy_q <= 1'b0;
         end
      end
   end

   // Datapath
   logic [IDX_W-1:0]    phase_idx;
   logic [SAMPLE_W-1:0] wave_lvl;
   logic [SAMPLE_W-1:0] duty_next;
   logic [SAMPLE_W-1:0] pwm_duty;

   tone_phase #(
      .PHASE_W (PHASE_W),
      .IDX_W   (IDX_W)
   ) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start_go),
      .advance (sample_adv),
      .step    (step_q),
      .idx     (phase_idx)
   );

   tone_wave #(
      .IDX_W    (IDX_W),
      .SAMPLE_W (SAMPLE_W),
      .LFSR_W   (LFSR_W),
      .SEED     (SEED)
   ) u_wave (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (wave_q),
      .idx       (phase_idx),
      .reseed    (start_go),
      .noise_adv (sample_adv),
      .level     (wave_lvl)
   );

   tone_scale #(
      .SAMPLE_W (SAMPLE_W),
      .AMP_W    (AMP_W),
      .CENTERED (CENTERED)
   ) u_scale (
      .level  (wave_lvl),
      .gain   (gain_q),
      .active (busy_q),
      .duty   (duty_next)
   );

   tone_pwm #(
      .WIDTH (SAMPLE_W)
   ) u_pwm (
      .clk     (clk),
      .rst_n   (rst_n),
      .duty_in (duty_next),
      .wrap    (tick),
      .duty    (pwm_duty),
      .pwm_out (pwm_out)
   );

   assign busy = busy_q;

   // R3: a playing note always has samples left
   a_r3_busy_has_samples: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (left_q != '0));

   // R3: the note can only end on a period boundary
   a_r3_end_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(tick));

   // R1: an idle boundary always loads the midpoint duty
   a_r1_idle_midpoint: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !busy_q) |=> (pwm_duty == MID));

   // R4: an accepted start restarts the waveform at index 0
   a_r4_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start_go |=> (phase_idx == '0));

   // R11: start with zero length leaves the voice idle
   a_r11_zero_len_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (start_wr && (len_q == '0) && !busy_q) |=> !busy_q);

endmodule

// File: tb/tone_voice_tb_top.sv
module tone_voice_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        pwm_out;
   logic        busy;

   int checks = 0;
   int fails  = 0;
   int ref_cnt;
   int exp_q[$];
   string tag_q[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   tone_voice dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .pwm_out (pwm_out),
      .busy    (busy)
   );

   // Bench-side period position (R2: period starts at first edge after reset)
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) ref_cnt <= 0;
      else        ref_cnt <= (ref_cnt + 1) % 256;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // Reference model of the requirements
   function automatic int wave_val(input int w, input int i, input int lf);
      int h;
      int o;
      case (w)
         0: begin
            h = i % 128;
            o = (h * (127 - h) * 127) / 4096;
            return (i < 128) ? 128 + o : 128 - o;
         end
         1: return (i < 128) ? 2 * i : 2 * (255 - i);
         2: return (i < 128) ? 255 : 0;
         3: return i;
         4: return lf & 255;
         default: return 128;
      endcase
   endfunction

   function automatic int lfsr_next(input int l);
      int fb;
      fb = ((l >> 15) ^ (l >> 14) ^ (l >> 12) ^ (l >> 3)) & 1;
      return ((l << 1) | fb) & 16'hFFFF;
   endfunction

   function automatic int scale(input int v, input int a);
      int s;
      s = (v - 128) * a;
      return 128 + (s >>> 8);
   endfunction

   task automatic wait_cnt(input int v);
      do @(negedge clk); while (ref_cnt != v);
   endtask

   task automatic write_reg(input int a, input int d);
      wr_en   = 1'b1;
      wr_addr = 3'(a);
      wr_data = 16'(d);
      @(negedge clk);
   endtask

   // Driver: computes expected per-period duties, then programs the voice
   task automatic play(input string tag, input int w, input int step,
                       input int amp, input int len);
      int ph;
      int lf;
      while (busy) @(negedge clk);
      wait_cnt(255);
      wait_cnt(255);
      wait_cnt(40);
      exp_q.push_back(128);
      tag_q.push_back("R1 idle level before note");
      ph = 0;
      lf = 16'hACE1;
      for (int k = 0; k < len; k++) begin
         exp_q.push_back(scale(wave_val(w, (ph >> 8) & 255, lf), amp));
         tag_q.push_back(tag);
         ph = (ph + step) & 16'hFFFF;
         lf = lfsr_next(lf);
      end
      exp_q.push_back(128);
      tag_q.push_back(len == 0 ? "R11 zero length stays silent" : "R3 silence after note");
      write_reg(0, w);
      write_reg(1, step);
      write_reg(2, amp);
      write_reg(3, len);
      write_reg(4, 0);
      wr_en = 1'b0;
      if (len == 0) begin
         check("R11 busy after zero-length start", int'(busy), 0);
      end else begin
         check("R3 busy after start", int'(busy), 1);
         repeat (len) wait_cnt(255);
         check("R3 busy through last sample", int'(busy), 1);
         @(negedge clk);
         check("R3 busy cleared at last sample", int'(busy), 0);
      end
   endtask

   // Monitor: measures high time of each period and compares with the queue (R2)
   initial begin
      int hi;
      hi = 0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            hi += int'(pwm_out);
            if (ref_cnt == 255) begin
               if (exp_q.size() > 0) begin
                  int e;
                  string t;
                  e = exp_q.pop_front();
                  t = tag_q.pop_front();
                  check({"R2 ", t}, hi, e);
               end
               hi = 0;
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 busy in reset", int'(busy), 0);
      rst_n = 1'b1;
      wait_cnt(5);
      check("R1 pin high early in idle period", int'(pwm_out), 1);
      wait_cnt(200);
      check("R1 pin low late in idle period", int'(pwm_out), 0);
      check("R1 busy idle after reset", int'(busy), 0);

      play("R8 sine R4 stride", 0, 16'h0800, 255, 32);
      play("R7 triangle", 1, 16'h0C00, 255, 22);
      play("R6 square", 2, 16'h1000, 255, 16);
      play("R5 sawtooth R10 gain 100", 3, 16'h0F00, 100, 20);
      play("R9 noise", 4, 16'h0100, 255, 24);
      play("R4 phase wrap sawtooth", 3, 16'hF000, 255, 6);
      play("R6 unused code midpoint", 6, 16'h1000, 255, 4);
      play("R10 zero gain", 0, 16'h0800, 0, 4);
      play("R11 zero length", 3, 16'h0800, 255, 0);
      play("R10 square gain 37", 2, 16'h2000, 37, 8);
      play("R9 noise replay reseeds", 4, 16'h0100, 200, 6);

      while (exp_q.size() > 0) @(negedge clk);
      wait_cnt(100);
      check("R1 idle after all notes", int'(busy), 0);
      finish_run();
   end

endmodule